// File: doc/BRIEF.md
# Clock-Stop SPI Master Serializer

This block moves one parallel word at a time over a four-wire serial link. It acts as the link master. A one-cycle `start` pulse latches the transmit word, the word length and the clock divider. The block then pulls the active-low select low and generates a serial clock from the reference clock. It shifts the word out MSB first and collects the word coming back from the slave. At the end it raises the select again and pulses `done`, and the received word is then ready on `rx_data`.

The serial clock stays low whenever no word is in flight. Its period is one more than the divider value, counted in reference cycles. When the divider is even, the high phase is one reference cycle longer than the low phase. A divider of zero is clamped to a two-cycle period. Select timing is built from the low-phase length:
- Select falls one low-phase before the first rising edge.
- Select rises one low-phase after the last falling edge.

Transmit bits change just after falling edges. Receive bits are captured on rising edges.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, `sclk` is 0, `ss_n` is 1, `mosi` is 0, and `busy` and `done` are 0.
- R2: While a word is in flight, each serial clock period lasts `clk_div`+1 reference cycles. A `clk_div` of 0 gives a period of 2 cycles.
- R3: For odd `clk_div`, high and low phases each last (`clk_div`+1)/2 cycles. For even non-zero `clk_div`, the low phase lasts `clk_div`/2 cycles and the high phase lasts `clk_div`/2+1 cycles. For `clk_div` of 0, each phase lasts 1 cycle.
- R4: `sclk` is 0 whenever `busy` is 0.
- R5: `ss_n` falls at the reference edge that accepts `start`, and stays low for exactly one low-phase before the first rising `sclk` edge.
- R6: After the last falling `sclk` edge, `ss_n` stays low for one low-phase and then returns high.
- R7: `mosi` carries `tx_data` MSB first. Bit `len`-1 appears when `ss_n` falls. Each later bit appears at a falling `sclk` edge. After the last falling edge, `mosi` is 0.
- R8: `miso` is sampled at each rising `sclk` edge. When `done` is high, `rx_data` holds the received bits right-aligned, first bit in position `len`-1, with zeros above.
- R9: A transfer issues exactly `len` clock pulses. `len` is `word_len` clamped to the range 4 to 32: requests below 4 become 4, and requests above 32 become 32.
- R10: `busy` stays high and `ss_n` stays low for the whole transfer. A `start` pulse while `busy` is high is ignored, and any input change during the transfer leaves the word in flight unchanged.
- R11: `done` is a single-cycle pulse in the cycle `ss_n` returns high. A new `start` is accepted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| tx_data | input | MAX_LEN | Word to send, right-aligned |
| word_len | input | LEN_W | Requested bits per word |
| clk_div | input | DIV_W | Serial clock divider value |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rx_data | output | MAX_LEN | Received word, right-aligned |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave |

## Verification
Every output is a register, so each result appears on the reference edge that causes it and is sampled on the following falling edge.

Take L and H as the low-phase and high-phase lengths in reference cycles. Counting from the edge that accepts `start`:
- `ss_n` and the first `mosi` bit change at that same edge.
- The first rising `sclk` edge comes L edges later.
- Each bit then takes H+L edges.
- `done` arrives one edge after the final low phase ends.

The bench model turns each accepted start into a per-cycle list of expected pin values, using those counts. It pops one entry per reference edge and compares every output on every cycle. Because of this, an early or late edge, a wrong phase split or a missing clock pulse fails in the exact cycle it occurs.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW
  } phase_e;

  // Reference cycles spent with the serial clock low in one period.
  function automatic int unsigned low_len(input int unsigned div);
    if (div == 0)       return 1;
    else if (div[0])    return (div + 1) / 2;
    else                return div / 2;
  endfunction

  // Reference cycles spent with the serial clock high in one period.
  function automatic int unsigned high_len(input int unsigned div);
    if (div == 0)       return 1;
    else if (div[0])    return (div + 1) / 2;
    else                return div / 2 + 1;
  endfunction

  // Bits per word actually used for a requested length.
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned maxw);
    if (req < 4)        return 4;
    else if (req > maxw) return maxw;
    else                return req;
  endfunction

endpackage

// File: rtl/spi_cs_clkgen.sv
module spi_cs_clkgen
  import spi_cs_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic [LEN_W-1:0] len_eff,
  output logic             busy,
  output logic             sclk,
  output logic             ss_n,
  output logic             load_ev,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             done
);

  localparam int CW = DIV_W;

  phase_e           ph;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    lo_q;
  logic [CW-1:0]    hi_q;
  logic [LEN_W-1:0] bits_left;
  logic             fs_q;
  logic             sclk_q;
  logic             done_q;

  logic [CW-1:0]    lo_now;
  logic [CW-1:0]    hi_now;
  logic             phase_end;
  logic             fin_ev;

  assign lo_now    = CW'(low_len(32'(div)));
  assign hi_now    = CW'(high_len(32'(div)));
  assign phase_end = (cnt == '0);

  assign load_ev = (ph == PH_IDLE) && start;
  assign rise_ev = phase_end && ((ph == PH_LEAD) ||
                                 ((ph == PH_LOW) && (bits_left != '0)));
  assign fall_ev = phase_end && (ph == PH_HIGH);
  assign fin_ev  = phase_end && (ph == PH_LOW) && (bits_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      bits_left <= '0;
      fs_q      <= 1'b0;
      sclk_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (load_ev) begin
            ph        <= PH_LEAD;
            fs_q      <= 1'b1;
            cnt       <= lo_now - 1'b1;
            lo_q      <= lo_now;
            hi_q      <= hi_now;
            bits_left <= len_eff;
          end
        end
        PH_LEAD, PH_LOW: begin
          if (fin_ev) begin
            ph     <= PH_IDLE;
            fs_q   <= 1'b0;
            done_q <= 1'b1;
          end else if (rise_ev) begin
            ph        <= PH_HIGH;
            sclk_q    <= 1'b1;
            cnt       <= hi_q - 1'b1;
            bits_left <= bits_left - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (fall_ev) begin
            ph     <= PH_LOW;
            sclk_q <= 1'b0;
            cnt    <= lo_q - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // Internal frame sync is active high; the pin is its inverse.
  assign ss_n = ~fs_q;
  assign sclk = sclk_q;
  assign busy = (ph != PH_IDLE);
  assign done = done_q;

  // Phase-length and pulse-count observers for the assertions below.
  logic [CW:0]      hi_run;
  logic [CW:0]      lo_run;
  logic [LEN_W-1:0] rise_cnt;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      lo_run   <= '0;
      rise_cnt <= '0;
      len_q    <= '0;
    end else begin
      if (load_ev) begin
        lo_run   <= 1;
        rise_cnt <= '0;
        len_q    <= len_eff;
      end else if (fall_ev) begin
        lo_run <= 1;
      end else if (!sclk_q) begin
        lo_run <= lo_run + 1'b1;
      end
      if (rise_ev) begin
        hi_run   <= 1;
        rise_cnt <= rise_cnt + 1'b1;
      end else if (sclk_q) begin
        hi_run <= hi_run + 1'b1;
      end
    end
  end

  // R3
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |-> (hi_run == {1'b0, hi_q}));

  // R5
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |-> (lo_run == {1'b0, lo_q}));

  // R9
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev |-> (rise_cnt == len_q));

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_ev,
  input  logic               rise_ev,
  input  logic               fall_ev,
  input  logic [MAX_LEN-1:0] tx_word,
  input  logic [LEN_W-1:0]   len_eff,
  input  logic               miso,
  output logic               mosi,
  output logic [MAX_LEN-1:0] rx_word
);

  logic [MAX_LEN-1:0] tx_sh;
  logic [MAX_LEN-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load_ev) begin
        // Left-align the active bits so the MSB sits at the top.
        tx_sh <= tx_word << (MAX_LEN - int'(len_eff));
        rx_sh <= '0;
      end else begin
        if (fall_ev) tx_sh <= {tx_sh[MAX_LEN-2:0], 1'b0};
        if (rise_ev) rx_sh <= {rx_sh[MAX_LEN-2:0], miso};
      end
    end
  end

  assign mosi    = tx_sh[MAX_LEN-1];
  assign rx_word = rx_sh;

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter  int MAX_LEN = 32,
  parameter  int DIV_W   = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [MAX_LEN-1:0] tx_data,
  input  logic [LEN_W-1:0]   word_len,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic               miso,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] rx_data,
  output logic               sclk,
  output logic               ss_n,
  output logic               mosi
);

  logic [LEN_W-1:0] len_eff;
  logic             load_ev;
  logic             rise_ev;
  logic             fall_ev;

  assign len_eff = LEN_W'(clamp_len(32'(word_len), MAX_LEN));

  spi_cs_clkgen #(
    .DIV_W (DIV_W),
    .LEN_W (LEN_W)
  ) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .div     (clk_div),
    .len_eff (len_eff),
    .busy    (busy),
    .sclk    (sclk),
    .ss_n    (ss_n),
    .load_ev (load_ev),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .done    (done)
  );

  spi_cs_shifter #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
  ) u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .tx_word (tx_data),
    .len_eff (len_eff),
    .miso    (miso),
    .mosi    (mosi),
    .rx_word (rx_data)
  );

  // R4
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R10
  select_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ss_n);

  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss_n && !busy));

  // R11
  release_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> done);

  // R5
  select_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> (busy && !sclk));

  // R7
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($fell(sclk) || $fell(ss_n)));

endmodule

// File: tb/spi_cs_master_bench.sv
module spi_cs_master_bench;

  localparam int MAXW = 32;
  localparam int DW   = 8;
  localparam int LW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [MAXW-1:0] tx_data = '0;
  logic [LW-1:0]   word_len = '0;
  logic [DW-1:0]   clk_div = '0;
  logic            miso = 1'b0;
  logic            busy, done, sclk, ss_n, mosi;
  logic [MAXW-1:0] rx_data;

  logic [MAXW-1:0] slave_word = '0;

  always #2 clk = ~clk;

  spi_cs_master u_spi_cs_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_data  (tx_data),
    .word_len (word_len),
    .clk_div  (clk_div),
    .miso     (miso),
    .busy     (busy),
    .done     (done),
    .rx_data  (rx_data),
    .sclk     (sclk),
    .ss_n     (ss_n),
    .mosi     (mosi)
  );

  int total = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Entry: {busy, done, ss_n, sclk, mosi, miso_to_drive}
  localparam logic [5:0] IDLE_E = 6'b001000;
  logic [5:0]      q[$];
  logic [5:0]      cur = IDLE_E;
  logic [MAXW-1:0] exp_rx = '0;

  task automatic plan(input int div, input int req_len,
                      input logic [MAXW-1:0] tx, input logic [MAXW-1:0] sw);
    int len, period, hi, lo;
    len    = (req_len < 4) ? 4 : ((req_len > MAXW) ? MAXW : req_len);
    period = (div < 1) ? 2 : div + 1;
    hi     = (period + 1) / 2;
    lo     = period - hi;
    for (int k = 0; k < lo; k++) q.push_back({4'b1000, tx[len-1], sw[len-1]});
    for (int i = len - 1; i >= 0; i--) begin
      for (int k = 0; k < hi; k++) q.push_back({4'b1001, tx[i], sw[i]});
      for (int k = 0; k < lo; k++)
        q.push_back({4'b1000, (i > 0) ? tx[i-1] : 1'b0, (i > 0) ? sw[i-1] : 1'b0});
    end
    q.push_back(6'b011000);
    exp_rx = (len == MAXW) ? sw : (sw & ((32'd1 << len) - 1));
  endtask

  // Reference model: one entry per reference edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = IDLE_E;
    end else begin
      if (start && !cur[5]) plan(int'(clk_div), int'(word_len), tx_data, slave_word);
      if (q.size() != 0) cur = q.pop_front();
      else               cur = IDLE_E;
    end
  end

  // Compare every output between edges and drive the slave bit.
  always @(negedge clk) begin
    miso = cur[0];
    if (rst_n && !finished) begin
      check("R2 R3 R4 R9 sclk", 32'(sclk), 32'(cur[2]));
      check("R5 R6 ss_n",       32'(ss_n), 32'(cur[3]));
      check("R7 mosi",          32'(mosi), 32'(cur[1]));
      check("R10 busy",         32'(busy), 32'(cur[5]));
      check("R11 done",         32'(done), 32'(cur[4]));
      if (cur[4]) check("R8 rx_data", rx_data, exp_rx);
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (cur[5] || q.size() != 0);
  endtask

  task automatic xfer(input int div, input int len,
                      input logic [MAXW-1:0] tx, input logic [MAXW-1:0] sw);
    @(negedge clk);
    clk_div = DW'(div); word_len = LW'(len); tx_data = tx; slave_word = sw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 sclk", 32'(sclk), 0);
    check("R1 ss_n", 32'(ss_n), 1);
    check("R1 mosi", 32'(mosi), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);

    // R3 odd divider, equal phases
    xfer(3, 8, 32'h0000_00A5, 32'h0000_003C);
    // R3 even divider, longer high phase
    xfer(4, 8, 32'h0000_005A, 32'h0000_00C3);
    // R2 zero divider clamped to period 2
    xfer(0, 4, 32'h0000_0009, 32'h0000_0006);
    // R9 full-width word, divider 1
    xfer(1, 32, 32'hDEAD_BEEF, 32'h1234_5678);
    // R9 short request clamped up to 4, upper tx bits ignored
    xfer(2, 2, 32'hFFFF_FFF6, 32'h0000_000B);
    // R9 long request clamped down to 32
    xfer(2, 40, 32'h8000_0001, 32'hF0F0_0F0F);

    // R10 start and new inputs during a transfer are ignored
    @(negedge clk);
    clk_div = 8'd6; word_len = 6'd12; tx_data = 32'h0000_0ABC; slave_word = 32'h0000_0531;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (9) @(negedge clk);
    clk_div = 8'd1; word_len = 6'd5; tx_data = 32'h0000_0013;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R11 back-to-back: start held so next word begins right after done
    @(negedge clk);
    clk_div = 8'd5; word_len = 6'd6; tx_data = 32'h0000_0029; slave_word = 32'h0000_0016;
    start = 1'b1;
    @(negedge clk);
    wait_idle();
    clk_div = 8'd2; word_len = 6'd7; tx_data = 32'h0000_0055; slave_word = 32'h0000_002A;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    // R6 lag and R4 idle clock verified cycle by cycle above
    repeat (5) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=busy expected=idle");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule